// File: doc/BRIEF.md
# Six-Bit Successive Approximation Converter Sequencer

This block is the digital half of a 6-bit successive-approximation analog-to-digital converter. It drives a 6-bit trial code into an external resistor-ladder DAC, reads back a single comparator bit, and decides one result bit per trial. The first trial is the most significant bit and the last is the least significant bit. The ladder is scaled so that one code step equals one ninety-sixth of the supply. The top code, 63, therefore corresponds to 63/96 of the supply, and any higher input settles at 63.

A one-cycle start request begins a conversion, which lasts a fixed number of clock cycles. That period is split into seven equal slots: one sample slot with the trial code at zero, then six trial slots. With the default of 1400 cycles per conversion and a 1.09375 MHz clock, one conversion takes 1.28 ms. When a conversion ends, the result register loads the whole new code at once and a one-cycle done pulse is raised. The result then holds until the next conversion finishes.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, trial_o and result_o are all 0.
- R2: A start_i pulse seen at a clock edge while busy_o is low sets busy_o from the next cycle. During the first slot (the sample slot), trial_o stays 0.
- R3: busy_o stays high for exactly CONV_CYCLES cycles (default 1400), which is seven slots of CONV_CYCLES/7 cycles each.
- R4: Trials run from the MSB down. In the first cycle of the second slot, trial_o equals 6'b100000 (32). Each later slot shows the bits already kept plus the next lower bit set.
- R5: A trial bit is kept only if cmp_i is 1 (input at or above the trial level) in the last cycle of that bit's slot.
- R6: With a comparator that switches half a step below each trial level (step = supply/96), result_o equals the input rounded to the nearest step.
- R7: Any input at or above 63/96 of the supply, less half a step, gives result_o = 63 (6'h3F).
- R8: A start_i while busy_o is high is ignored. The conversion keeps its length, and its result is unaffected.
- R9: done_o is a one-cycle pulse in the first cycle after busy_o falls. result_o changes only in that cycle and otherwise holds its value.
- R10: trial_o is 0 whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled at each clock edge |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the ladder level |
| trial_o | output | 6 | Trial code driven to the ladder DAC |
| busy_o | output | 1 | High while a conversion is running |
| done_o | output | 1 | One-cycle pulse when a new result is loaded |
| result_o | output | 6 | Last completed conversion result |

## Verification
The assertions assume that cmp_i is a settled function of trial_o and the held analog input in the last cycle of each slot. They also assume that start_i is a clean synchronous level. The bench's ladder and comparator model responds combinationally to trial_o, and the modelled input changes only while the block is idle. The one exception is the held-result test, which changes the input with no start request; it shows that result_o does not move. Start pulses are driven on falling edges, one of them in the middle of a running conversion.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int ADC_BITS = 6;
  localparam int NSLOT    = ADC_BITS + 1;
  localparam int SLOT_W   = $clog2(NSLOT);

  typedef logic [ADC_BITS-1:0] code_t;
  typedef logic [SLOT_W-1:0]   slot_t;

  // bit decided at the end of a slot (none in the sample slot)
  function automatic code_t judged_mask(slot_t s);
    if (s == '0 || int'(s) > ADC_BITS) return '0;
    return code_t'(1) << (ADC_BITS - int'(s));
  endfunction

  // bit proposed for the next slot (none after the last trial)
  function automatic code_t probe_mask(slot_t s);
    if (int'(s) >= ADC_BITS) return '0;
    return code_t'(1) << (ADC_BITS - 1 - int'(s));
  endfunction

  // trial code after the end of slot s, given the comparator verdict
  function automatic code_t sar_step(code_t code, slot_t s, logic cmp);
    code_t r;
    r = code;
    if (!cmp) r = r & ~judged_mask(s);
    r = r | probe_mask(s);
    return r;
  endfunction
endpackage

// File: rtl/sar_slot_timer.sv
module sar_slot_timer
  import sar_adc_pkg::*;
#(
  parameter int SLOT_CYCLES = 200
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  output logic  accept_o,
  output logic  busy_o,
  output slot_t slot_o,
  output logic  slot_end_o,
  output logic  conv_end_o
);
  localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SLOT_CYCLES - 1);
  localparam slot_t            SLOT_LAST = SLOT_W'(NSLOT - 1);

  logic [CNT_W-1:0] cnt_q;
  slot_t            slot_q;
  logic             busy_q;

  assign accept_o   = start_i & ~busy_q;
  assign slot_end_o = busy_q & (cnt_q == CNT_LAST);
  assign conv_end_o = slot_end_o & (slot_q == SLOT_LAST);
  assign busy_o     = busy_q;
  assign slot_o     = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (slot_q == SLOT_LAST) begin
          busy_q <= 1'b0;
          slot_q <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(slot_q) < NSLOT));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !conv_end_o) |=> busy_q);
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (busy_q && slot_q == '0 && cnt_q == '0));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_adc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept_i,
  input  logic  slot_end_i,
  input  logic  conv_end_i,
  input  slot_t slot_i,
  input  logic  cmp_i,
  output code_t code_o,
  output code_t next_code_o
);
  code_t code_q;
  code_t judged;

  assign judged      = judged_mask(slot_i);
  assign next_code_o = sar_step(code_q, slot_i, cmp_i);
  assign code_o      = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           code_q <= '0;
    else if (accept_i)    code_q <= '0;
    else if (conv_end_i)  code_q <= '0;
    else if (slot_end_i)  code_q <= next_code_o;
  end

  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_i && slot_i == '0) |=> (code_q == code_t'(1) << (ADC_BITS - 1)));
  a_r5_keep_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_i && !conv_end_i && slot_i != '0) |=>
      (((code_q & $past(judged)) != '0) == $past(cmp_i)));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int CONV_CYCLES = 1400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic [ADC_BITS-1:0] trial_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [ADC_BITS-1:0] result_o
);
  localparam int SLOT_CYCLES = CONV_CYCLES / NSLOT;

  logic  accept, slot_end, conv_end, busy;
  slot_t slot;
  code_t code, next_code;
  code_t result_q;
  logic  done_q;

  sar_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .accept_o   (accept),
    .busy_o     (busy),
    .slot_o     (slot),
    .slot_end_o (slot_end),
    .conv_end_o (conv_end)
  );

  sar_bit_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .slot_end_i  (slot_end),
    .conv_end_i  (conv_end),
    .slot_i      (slot),
    .cmp_i       (cmp_i),
    .code_o      (code),
    .next_code_o (next_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= conv_end;
      if (conv_end) result_q <= next_code;
    end
  end

  assign trial_o  = code;
  assign busy_o   = busy;
  assign done_o   = done_q;
  assign result_o = result_q;

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r9_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(busy)));
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(result_q));
  a_r10_idle_trial: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (code == '0));
endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  localparam int CLK_PERIOD  = 10;
  localparam int CONV_CYCLES = 1400;
  localparam int SLOT_CYCLES = CONV_CYCLES / 7;
  localparam int STEP_MV     = 50;   // supply 4800 mV / 96
  localparam int NVEC        = 12;
  // {input in mV, expected nearest code}
  localparam int VEC [NVEC][2] = '{
    '{0, 0}, '{24, 0}, '{25, 1}, '{1000, 20}, '{1574, 31}, '{1575, 32},
    '{2400, 48}, '{3124, 62}, '{3149, 63}, '{3150, 63}, '{4000, 63}, '{4800, 63}};

  logic clk = 0, rst_n = 0, start_i = 0, cmp_i;
  logic [5:0] trial_o, result_o;
  logic busy_o, done_o;
  int vin_mv = 0;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ladder and comparator model: switch half a step below each level
  always_comb cmp_i = (vin_mv >= int'(trial_o) * STEP_MV - STEP_MV / 2);

  sar_adc_ctrl #(.CONV_CYCLES(CONV_CYCLES)) i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .trial_o(trial_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one conversion; optionally a second start in the middle (R8)
  task automatic convert(input int vin, input int exp, input bit poke);
    int n;
    vin_mv = vin;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    check(trial_o == 6'd0, "R2 sample slot trial", int'(trial_o), 0);
    n = 1;
    while (busy_o && n < 5000) begin
      @(negedge clk);
      if (busy_o) n++;
      if (n == SLOT_CYCLES + 1 && busy_o)
        check(trial_o == 6'd32, "R4 first trial MSB", int'(trial_o), 32);
      if (poke && n == CONV_CYCLES / 2) start_i = 1;
      else start_i = 0;
    end
    check(n == CONV_CYCLES, "R3 busy length", n, CONV_CYCLES);
    check(done_o == 1'b1, "R9 done at busy fall", int'(done_o), 1);
    check(int'(result_o) == exp, "R6 R7 result", int'(result_o), exp);
    check(trial_o == 6'd0, "R10 idle trial", int'(trial_o), 0);
    @(negedge clk);
    check(done_o == 1'b0, "R9 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R1 reset flags", int'(busy_o), 0);
    check(trial_o == 0 && result_o == 0, "R1 reset codes", int'(result_o), 0);
    rst_n = 1;
    for (int i = 0; i < NVEC; i++) convert(VEC[i][0], VEC[i][1], 1'b0);
    // R5: a bit pattern exercising keep and drop alternately (code 42)
    convert(42 * STEP_MV, 42, 1'b0);
    convert(21 * STEP_MV + 10, 21, 1'b0);
    // R8: start during conversion is ignored
    convert(1234, 25, 1'b1);
    // R9: result holds when the input changes with no start
    vin_mv = 4800;
    repeat (60) @(negedge clk);
    check(result_o == 6'd25, "R9 result holds", int'(result_o), 25);
    check(busy_o == 1'b0, "R8 no restart", int'(busy_o), 0);
    // R7 saturation after a low value
    convert(4800, 63, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule